// File: doc/BRIEF.md
# UART Receive Character Classifier with Break Measurement

This block sits between a UART character deserializer and the consumer of received characters. For each character strobe it works out the error status of that character: parity error, missing stop bit (framing error) or line break. It then stores the character together with its status in a receive queue that holds exactly two entries. If a third character arrives while both entries are still occupied, that character is lost and the loss is marked on the newest stored entry.

Next to the queue, the block runs three pieces of line monitoring. It counts consecutive all-ones (idle) characters. It counts break events and raises a break pulse that can be masked. It measures how many bit times each break lasts and keeps the most recent length in a register. The break counter and the length register can be cleared with a single-cycle clear input.

Bit sampling and baud generation are done upstream. The block relies on a one-cycle strobe per character, a bit-time tick, and the raw line level.

Top module: `uart_rx_err_classify`

## Requirements
- R1: After reset the queue is empty (`q_vld`=0), and `brk_count`, `brk_len` and `idle_count` are all zero.
- R2: The queue holds up to two characters and presents them in arrival order. `q_vld` is 1 while at least one entry is stored, and a `pop` removes the head entry.
- R3: A strobe that arrives while two entries are stored and `pop` is low discards the new character and sets the overrun bit `q_ov` on the second (newest) stored entry.
- R4: A character with `in_stop_ok`=1 and `in_par_ok`=0 is stored with `q_pe`=1 and `q_fe`=0.
- R5: A character with `in_stop_ok`=0 and non-zero data is stored with `q_fe`=1. `q_pe` is 0 whatever the value of `in_par_ok`.
- R6: A character with all-zero data and `in_stop_ok`=0 is stored as a break: `q_brk`=1, `q_fe`=0, `q_pe`=0. `brk_pulse` is high for exactly the one cycle after the strobe. `brk_irq` equals `brk_pulse` when `brk_ie`=1 and stays 0 when `brk_ie`=0.
- R7: Each break character increments `brk_count` by one. The new value is visible in the cycle after the strobe.
- R8: A break starts a measurement at DW+2 bit times (10 for 8-bit data). Each `tick` while `line_lvl` is low adds one. In the first cycle after the strobe in which `line_lvl` is high, the count is copied into `brk_len`.
- R9: The measured break length saturates at 2^LW-1 (255 by default).
- R10: An all-ones character increments `idle_count`, which saturates at 2^IW-1. Any other character resets it to zero.
- R11: A one-cycle `wclr` sets `brk_count` and `brk_len` to zero. It takes priority over an increment or latch in the same cycle.
- R12: A `pop` while the queue is empty has no effect. The next character stored becomes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_stb | input | 1 | One-cycle strobe per received character |
| in_data | input | DW | Received character |
| in_stop_ok | input | 1 | Stop bit was sampled high |
| in_par_ok | input | 1 | Parity matched |
| tick | input | 1 | One pulse per bit time |
| line_lvl | input | 1 | Current receive line level |
| pop | input | 1 | Consumer removes the head entry |
| wclr | input | 1 | Clear break counter and break length |
| brk_ie | input | 1 | Break interrupt enable |
| q_vld | output | 1 | Queue head is valid |
| q_data | output | DW | Head character |
| q_ov | output | 1 | Head overrun flag |
| q_pe | output | 1 | Head parity error flag |
| q_fe | output | 1 | Head framing error flag |
| q_brk | output | 1 | Head break flag |
| brk_pulse | output | 1 | One-cycle break event |
| brk_irq | output | 1 | Break event gated by enable |
| brk_count | output | CW | Break event count |
| brk_len | output | LW | Last measured break length in bit times |
| idle_count | output | IW | Consecutive idle characters |

## Verification
The assertions take the inputs as the deserializer delivers them:
- `in_stb` is a single-cycle pulse per character.
- `tick` is a single-cycle pulse.
- `line_lvl` is held low from the break strobe until the line recovers.

Their properties also rely on the queue occupancy never exceeding two, whatever the ordering of `pop` and `in_stb`. The directed tasks drive every input on the falling edge and raise each strobe for exactly one cycle. They keep `line_lvl` low across every break strobe and release it only after the chosen number of ticks, so the measured lengths are known in advance.

// File: rtl/uerr_pkg.sv
package uerr_pkg;

   // status bits carried with every queued character
   typedef struct packed {
      logic ov;
      logic pe;
      logic fe;
      logic brk;
   } uerr_flags_t;

   // bit times already spent low when a break strobe arrives: start + missing stop
   localparam int unsigned BRK_OVERHEAD = 2;

   // exact queue depth
   localparam int unsigned Q_DEPTH = 2;

endpackage

// File: rtl/uerr_classify.sv
module uerr_classify
   import uerr_pkg::*;
#(
   parameter int unsigned DW     = 8,
   parameter bit          PAR_EN = 1'b1
) (
   input  logic [DW-1:0] data,
   input  logic          stop_ok,
   input  logic          par_ok,
   output uerr_flags_t   flags,
   output logic          is_idle,
   output logic          is_brk
);

   logic no_stop;
   logic all_zero;
   logic par_bad;

   assign no_stop  = ~stop_ok;
   assign all_zero = (data == '0);
   assign is_idle  = (data == '1);
   assign is_brk   = no_stop & all_zero;

   generate
      if (PAR_EN) begin : g_par
         // parity only judged when the frame itself is sound
         assign par_bad = stop_ok & ~par_ok;
      end else begin : g_nopar
         logic unused_par;
         assign unused_par = par_ok;
         assign par_bad    = 1'b0;
      end
   endgenerate

   always_comb begin
      flags     = '0;
      flags.brk = is_brk;
      flags.fe  = no_stop & ~all_zero;
      flags.pe  = par_bad;
   end

endmodule

// File: rtl/uerr_fifo2.sv
module uerr_fifo2
   import uerr_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  uerr_flags_t   wflags,
   input  logic          rd,
   output logic          vld,
   output logic [DW-1:0] rdata,
   output uerr_flags_t   rflags
);

   typedef struct packed {
      logic [DW-1:0] d;
      uerr_flags_t   f;
   } ent_t;

   ent_t       mem [Q_DEPTH];
   logic [1:0] cnt;
   logic       full;
   logic       do_pop;
   logic       push_ok;
   logic       ovr;
   logic [1:0] wr_idx;

   assign full    = (cnt == 2'(Q_DEPTH));
   assign do_pop  = rd & (cnt != 2'd0);
   assign push_ok = wr & (~full | do_pop);
   assign ovr     = wr & full & ~do_pop;
   assign wr_idx  = cnt - 2'(do_pop);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         for (int i = 0; i < Q_DEPTH; i++) mem[i] <= '0;
      end else begin
         if (do_pop) mem[0] <= mem[1];
         if (push_ok) begin
            mem[wr_idx[0]].d <= wdata;
            mem[wr_idx[0]].f <= wflags;
         end else if (ovr) begin
            mem[1].f.ov <= 1'b1;
         end
         cnt <= cnt + 2'(push_ok) - 2'(do_pop);
      end
   end

   assign vld    = (cnt != 2'd0);
   assign rdata  = mem[0].d;
   assign rflags = mem[0].f;

   initial begin
      assert (DW >= 5) else $error("uerr_fifo2: DW must be at least 5");
   end

   a_r2_depth_bound : assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= 2'(Q_DEPTH));

   a_r3_overrun_marks : assert property (@(posedge clk) disable iff (!rst_n)
      ovr |=> (cnt == 2'(Q_DEPTH)) && mem[1].f.ov);

   a_r12_empty_pop : assert property (@(posedge clk) disable iff (!rst_n)
      (rd && (cnt == 2'd0) && !wr) |=> (cnt == 2'd0));

endmodule

// File: rtl/uerr_brk_meter.sv
module uerr_brk_meter
   import uerr_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned LW = 8,
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          brk_hit,
   input  logic          tick,
   input  logic          line_lvl,
   input  logic          wclr,
   output logic          brk_evt,
   output logic [CW-1:0] brk_cnt,
   output logic [LW-1:0] brk_len
);

   localparam logic [LW-1:0] LEN_MAX   = '1;
   localparam logic [LW-1:0] LEN_START = LW'(DW + BRK_OVERHEAD);

   logic          meas;
   logic [LW-1:0] mcnt;
   logic          done;

   assign done = meas & line_lvl & ~brk_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         meas    <= 1'b0;
         mcnt    <= '0;
         brk_evt <= 1'b0;
         brk_cnt <= '0;
         brk_len <= '0;
      end else begin
         brk_evt <= brk_hit;
         if (brk_hit) begin
            meas <= 1'b1;
            mcnt <= LEN_START;
         end else if (meas) begin
            if (line_lvl) meas <= 1'b0;
            else if (tick && (mcnt != LEN_MAX)) mcnt <= mcnt + 1'b1;
         end
         if (wclr) begin
            brk_cnt <= '0;
            brk_len <= '0;
         end else begin
            if (brk_hit) brk_cnt <= brk_cnt + 1'b1;
            if (done)    brk_len <= mcnt;
         end
      end
   end

   initial begin
      assert (LW >= 4 && (2 ** LW) - 1 >= DW + BRK_OVERHEAD)
         else $error("uerr_brk_meter: LW too small for DW");
      assert (CW >= 1) else $error("uerr_brk_meter: CW must be positive");
   end

   a_r6_pulse_follows : assert property (@(posedge clk) disable iff (!rst_n)
      brk_hit |=> brk_evt);

   a_r7_count_step : assert property (@(posedge clk) disable iff (!rst_n)
      (brk_hit && !wclr) |=> (brk_cnt == $past(brk_cnt) + 1'b1));

   a_r9_len_saturates : assert property (@(posedge clk) disable iff (!rst_n)
      (meas && !brk_hit && !line_lvl && (mcnt == LEN_MAX)) |=> (mcnt == LEN_MAX));

   a_r11_clear_wins : assert property (@(posedge clk) disable iff (!rst_n)
      wclr |=> (brk_cnt == '0) && (brk_len == '0));

endmodule

// File: rtl/uart_rx_err_classify.sv
module uart_rx_err_classify
   import uerr_pkg::*;
#(
   parameter int unsigned DW     = 8,
   parameter bit          PAR_EN = 1'b1,
   parameter int unsigned LW     = 8,
   parameter int unsigned CW     = 16,
   parameter int unsigned IW     = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_stb,
   input  logic [DW-1:0] in_data,
   input  logic          in_stop_ok,
   input  logic          in_par_ok,
   input  logic          tick,
   input  logic          line_lvl,
   input  logic          pop,
   input  logic          wclr,
   input  logic          brk_ie,
   output logic          q_vld,
   output logic [DW-1:0] q_data,
   output logic          q_ov,
   output logic          q_pe,
   output logic          q_fe,
   output logic          q_brk,
   output logic          brk_pulse,
   output logic          brk_irq,
   output logic [CW-1:0] brk_count,
   output logic [LW-1:0] brk_len,
   output logic [IW-1:0] idle_count
);

   localparam logic [IW-1:0] IDLE_MAX = '1;

   uerr_flags_t c_flags;
   uerr_flags_t h_flags;
   logic        c_idle;
   logic        c_brk;

   uerr_classify #(.DW(DW), .PAR_EN(PAR_EN)) u_cls (
      .data    (in_data),
      .stop_ok (in_stop_ok),
      .par_ok  (in_par_ok),
      .flags   (c_flags),
      .is_idle (c_idle),
      .is_brk  (c_brk)
   );

   uerr_fifo2 #(.DW(DW)) u_q (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (in_stb),
      .wdata  (in_data),
      .wflags (c_flags),
      .rd     (pop),
      .vld    (q_vld),
      .rdata  (q_data),
      .rflags (h_flags)
   );

   uerr_brk_meter #(.DW(DW), .LW(LW), .CW(CW)) u_brk (
      .clk      (clk),
      .rst_n    (rst_n),
      .brk_hit  (in_stb & c_brk),
      .tick     (tick),
      .line_lvl (line_lvl),
      .wclr     (wclr),
      .brk_evt  (brk_pulse),
      .brk_cnt  (brk_count),
      .brk_len  (brk_len)
   );

   assign q_ov    = h_flags.ov;
   assign q_pe    = h_flags.pe;
   assign q_fe    = h_flags.fe;
   assign q_brk   = h_flags.brk;
   assign brk_irq = brk_pulse & brk_ie;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_count <= '0;
      end else if (in_stb) begin
         if (!c_idle)                    idle_count <= '0;
         else if (idle_count != IDLE_MAX) idle_count <= idle_count + 1'b1;
      end
   end

   initial begin
      assert (IW >= 1) else $error("uart_rx_err_classify: IW must be positive");
   end

   a_r5_fe_excludes : assert property (@(posedge clk) disable iff (!rst_n)
      (q_vld && q_fe) |-> (!q_pe && !q_brk));

   a_r10_idle_reset : assert property (@(posedge clk) disable iff (!rst_n)
      (in_stb && (in_data != '1)) |=> (idle_count == '0));

   a_r6_irq_masked : assert property (@(posedge clk) disable iff (!rst_n)
      !brk_ie |-> !brk_irq);

endmodule

// File: tb/sim_uart_rx_err_classify.sv
module sim_uart_rx_err_classify;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_stb = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_stop_ok = 1'b1;
   logic        in_par_ok = 1'b1;
   logic        tick = 1'b0;
   logic        line_lvl = 1'b1;
   logic        pop = 1'b0;
   logic        wclr = 1'b0;
   logic        brk_ie = 1'b0;
   logic        q_vld, q_ov, q_pe, q_fe, q_brk, brk_pulse, brk_irq;
   logic [7:0]  q_data;
   logic [15:0] brk_count;
   logic [7:0]  brk_len;
   logic [7:0]  idle_count;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   uart_rx_err_classify u0 (
      .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_data(in_data),
      .in_stop_ok(in_stop_ok), .in_par_ok(in_par_ok), .tick(tick),
      .line_lvl(line_lvl), .pop(pop), .wclr(wclr), .brk_ie(brk_ie),
      .q_vld(q_vld), .q_data(q_data), .q_ov(q_ov), .q_pe(q_pe),
      .q_fe(q_fe), .q_brk(q_brk), .brk_pulse(brk_pulse), .brk_irq(brk_irq),
      .brk_count(brk_count), .brk_len(brk_len), .idle_count(idle_count)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] d, input logic stop, input logic par);
      @(negedge clk);
      in_stb = 1'b1; in_data = d; in_stop_ok = stop; in_par_ok = par;
      @(negedge clk);
      in_stb = 1'b0; in_stop_ok = 1'b1; in_par_ok = 1'b1;
   endtask

   task automatic pop_one();
      @(negedge clk);
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
   endtask

   task automatic flush();
      for (int i = 0; i < 3; i++) pop_one();
   endtask

   task automatic t_reset();
      chk("R1 q_vld", 32'(q_vld), 0);
      chk("R1 brk_count", 32'(brk_count), 0);
      chk("R1 brk_len", 32'(brk_len), 0);
      chk("R1 idle_count", 32'(idle_count), 0);
   endtask

   task automatic t_order();
      send(8'hA5, 1, 1);
      send(8'h3C, 1, 1);
      chk("R2 head first", 32'(q_data), 32'hA5);
      chk("R2 valid", 32'(q_vld), 1);
      pop_one();
      chk("R2 head second", 32'(q_data), 32'h3C);
      chk("R2 second clean", 32'({q_ov, q_pe, q_fe, q_brk}), 0);
      pop_one();
      chk("R2 empty after pops", 32'(q_vld), 0);
   endtask

   task automatic t_overrun();
      send(8'h11, 1, 1);
      send(8'h22, 1, 1);
      send(8'h33, 1, 1);
      chk("R3 head kept", 32'(q_data), 32'h11);
      chk("R3 head no ov", 32'(q_ov), 0);
      pop_one();
      chk("R3 newest kept", 32'(q_data), 32'h22);
      chk("R3 newest ov", 32'(q_ov), 1);
      pop_one();
      chk("R3 third dropped", 32'(q_vld), 0);
   endtask

   task automatic t_parity();
      send(8'h5A, 1, 0);
      chk("R4 pe", 32'(q_pe), 1);
      chk("R4 fe", 32'(q_fe), 0);
      pop_one();
   endtask

   task automatic t_framing();
      send(8'h5A, 0, 0);
      chk("R5 fe", 32'(q_fe), 1);
      chk("R5 pe suppressed", 32'(q_pe), 0);
      chk("R5 brk", 32'(q_brk), 0);
      pop_one();
   endtask

   task automatic t_break();
      brk_ie = 1'b1;
      line_lvl = 1'b0;
      send(8'h00, 0, 0);
      chk("R6 pulse", 32'(brk_pulse), 1);
      chk("R6 irq enabled", 32'(brk_irq), 1);
      chk("R6 stored brk", 32'({q_brk, q_fe, q_pe}), 32'b100);
      chk("R7 count one", 32'(brk_count), 1);
      @(negedge clk);
      chk("R6 pulse one cycle", 32'(brk_pulse), 0);
      // four more ticks: pulses are applied at the following negedges
      for (int i = 0; i < 4; i++) begin
         tick = 1'b1;
         @(negedge clk);
      end
      tick = 1'b0;
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      line_lvl = 1'b1;
      @(negedge clk);
      chk("R8 length 10+5", 32'(brk_len), 15);
      pop_one();
      brk_ie = 1'b0;
      line_lvl = 1'b0;
      send(8'h00, 0, 1);
      chk("R6 pulse masked irq", 32'({brk_pulse, brk_irq}), 32'b10);
      chk("R7 count two", 32'(brk_count), 2);
      line_lvl = 1'b1;
      @(negedge clk);
      chk("R8 length no ticks", 32'(brk_len), 10);
      pop_one();
   endtask

   task automatic t_sat();
      line_lvl = 1'b0;
      send(8'h00, 0, 0);
      tick = 1'b1;
      for (int i = 0; i < 260; i++) @(negedge clk);
      tick = 1'b0;
      line_lvl = 1'b1;
      @(negedge clk);
      chk("R9 length saturated", 32'(brk_len), 255);
      flush();
   endtask

   task automatic t_idle();
      for (int i = 0; i < 3; i++) send(8'hFF, 1, 1);
      chk("R10 idle three", 32'(idle_count), 3);
      send(8'h00, 1, 1);
      chk("R10 idle cleared", 32'(idle_count), 0);
      for (int i = 0; i < 300; i++) send(8'hFF, 1, 1);
      chk("R10 idle saturated", 32'(idle_count), 255);
      send(8'h7F, 1, 1);
      chk("R10 idle cleared again", 32'(idle_count), 0);
      flush();
   endtask

   task automatic t_clear();
      chk("R11 precondition count", 32'(brk_count != 0), 1);
      @(negedge clk);
      wclr = 1'b1;
      @(negedge clk);
      wclr = 1'b0;
      chk("R11 count cleared", 32'(brk_count), 0);
      chk("R11 length cleared", 32'(brk_len), 0);
      // clear coincident with a break strobe
      line_lvl = 1'b0;
      @(negedge clk);
      in_stb = 1'b1; in_data = 8'h00; in_stop_ok = 1'b0; wclr = 1'b1;
      @(negedge clk);
      in_stb = 1'b0; in_stop_ok = 1'b1; wclr = 1'b0;
      chk("R11 clear beats increment", 32'(brk_count), 0);
      line_lvl = 1'b1;
      @(negedge clk);
      chk("R8 latch after clear", 32'(brk_len), 10);
      flush();
   endtask

   task automatic t_empty_pop();
      flush();
      pop_one();
      chk("R12 still empty", 32'(q_vld), 0);
      send(8'h77, 1, 1);
      chk("R12 head after empty pop", 32'(q_data), 32'h77);
      chk("R12 valid", 32'(q_vld), 1);
      pop_one();
      chk("R12 empty again", 32'(q_vld), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_order();
      t_overrun();
      t_parity();
      t_framing();
      t_break();
      t_sat();
      t_idle();
      t_clear();
      t_empty_pop();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < 100000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule